// File: doc/BRIEF.md
# DRAM Initialization Command Translator

This block sits between a host memory-access port and an SDRAM/DDR command bus. While memory is being brought up, software stores a 3-bit mode code. That code decides what each host access becomes on the memory pins:

- a NOP;
- a precharge of all banks;
- a mode-register load;
- an extended mode-register load;
- an auto refresh;
- in the normal code, a forwarded access on a pass-through strobe, with the memory bus left idle.

Every host access gets exactly one acknowledge, in the same cycle as the command it produced.

The block also owns the clock-enable lanes. After reset they stay low until software stores a non-zero code. A power-management level request makes the block wait for an external count of outstanding commands to drain. It then issues a refresh while dropping CKE, which puts the memory into self-refresh. When the request goes away, the block brings the memory back without software. A suspend request takes the same entry path, but only a reset leaves the resulting hold.

The state machine has seven states:

- `ST_CKE_OFF`: after reset, CKE is low and accesses are held.
- `ST_RUN`: accesses are translated.
- `ST_FLUSH`: waits for the outstanding-command count to reach zero.
- `ST_SR_ENTRY`: the single cycle in which the refresh goes out with CKE falling.
- `ST_SR_HOLD`: self-refresh that the level request can leave.
- `ST_SR_EXIT`: CKE is high again and NOPs are emitted for `EXIT_NOPS` cycles.
- `ST_SUSP_HOLD`: self-refresh that only a reset leaves.

The transitions are:

- `ST_CKE_OFF`→`ST_RUN` on a non-zero stored code.
- `ST_RUN`→`ST_FLUSH` on either power request.
- `ST_FLUSH`→`ST_SR_ENTRY` when the count is zero.
- `ST_SR_ENTRY`→`ST_SR_HOLD`, or →`ST_SUSP_HOLD` when a suspend was seen.
- `ST_SR_HOLD`→`ST_SUSP_HOLD` on suspend.
- `ST_SR_HOLD`→`ST_SR_EXIT` when the level request drops.
- `ST_SR_EXIT`→`ST_RUN` once the NOP count is done.

Top module: `dram_init_xlate`

## Requirements
- R1: While reset is held and after it is released, the stored mode reads 000, every CKE lane is 0, the bus shows NOP, and `host_ack` and `pass_valid` are 0.
- R2: The CKE lanes always carry one common value. They stay low while the stored mode has never been non-zero since reset, and host accesses get no acknowledge then. All lanes rise one cycle after the stored mode first becomes non-zero; the stored mode itself changes one cycle after the write.
- R3: Writing code 101 leaves the stored mode unchanged, and 101 is never stored.
- R4: A host access is translated from the stored mode as follows. Codes 000 and 001 give a NOP: {cs,ras,cas,we}=0111, MA=0. Code 010 gives precharge-all: 0010 with only MA[10] set. Code 110 gives auto refresh: 0001, MA=0. BA is 0 for all of these.
- R5: Code 011 gives a mode-register load and code 100 an extended mode-register load. Both drive {cs,ras,cas,we}=0000 and MA[12:0]=host_addr[15:3]. BA is 00 for 011 and 01 for 100.
- R6: Each access held on `host_req` produces exactly one command cycle, with `host_ack` high in that same cycle and one cycle after acceptance. The following cycle has `host_ack` low and a NOP on the bus.
- R7: With code 111, an access raises `pass_valid` together with `host_ack`, puts `host_addr` on `pass_addr`, and leaves a NOP on the bus.
- R8: A power request during `ST_RUN` stops acceptance while CKE stays high and the bus stays NOP, for as long as `pend_cnt` is non-zero. Then, in the cycle after the count is seen at zero, refresh (0001) is driven as CKE falls.
- R9: When the level request drops during self-refresh, CKE rises with a NOP and no software write. Exactly EXIT_NOPS+1 cycles of NOP with CKE high, counting the rising cycle, pass before the next access is translated under the unchanged mode.
- R10: After a suspend request, the block enters self-refresh through the same flush and refresh path. CKE then stays low whatever the power inputs do, until reset; after that reset, R2 applies again.
- R11: No access is acknowledged during the flush, self-refresh or exit cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_wr_en | input | 1 | Mode code write strobe |
| mode_wr_data | input | 3 | Mode code to store |
| mode_q | output | 3 | Stored mode code |
| host_req | input | 1 | Host access request, held until acknowledged |
| host_addr | input | HADDR_W | Host access address |
| host_ack | output | 1 | One-cycle acknowledge of an access |
| pass_valid | output | 1 | Forwarded normal-mode access strobe |
| pass_addr | output | HADDR_W | Forwarded access address |
| susp_req | input | 1 | Suspend request (leave only through reset) |
| lp_req | input | 1 | Level low-power request, self-refresh while high |
| pend_cnt | input | CNT_W | Count of outstanding commands to drain |
| dram_cke | output | NCKE | Clock-enable lanes |
| dram_cs_n | output | 1 | Chip select, active low |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_ba | output | BA_W | Bank address |
| dram_ma | output | MA_W | Memory address |

## Verification
The bench uses the defaults: two CKE lanes, a 16-bit host address with bits 15:3 mapped onto 13 memory address bits, a 4-bit outstanding count, and EXIT_NOPS of 2. With these values, all eight mode codes can be swept in turn, each with three address patterns that set, clear and alternate the bits that reach MA. The short exit window lets the exact NOP count after CKE rises be checked. A count starting at three shows that refresh entry is held off until the drain completes.

// File: rtl/dix_pkg.sv
package dix_pkg;

    typedef enum logic [2:0] {
        MD_IDLE = 3'd0,
        MD_NOP  = 3'd1,
        MD_PREA = 3'd2,
        MD_MRS  = 3'd3,
        MD_EMRS = 3'd4,
        MD_RSVD = 3'd5,
        MD_AREF = 3'd6,
        MD_NORM = 3'd7
    } mode_e;

    typedef enum logic [2:0] {
        CK_NOP,
        CK_PREA,
        CK_MRS,
        CK_EMRS,
        CK_AREF
    } cmd_e;

    typedef enum logic [2:0] {
        ST_CKE_OFF,
        ST_RUN,
        ST_FLUSH,
        ST_SR_ENTRY,
        ST_SR_HOLD,
        ST_SR_EXIT,
        ST_SUSP_HOLD
    } state_e;

    function automatic cmd_e mode_to_cmd(input mode_e m);
        cmd_e c;
        case (m)
            MD_PREA: c = CK_PREA;
            MD_MRS:  c = CK_MRS;
            MD_EMRS: c = CK_EMRS;
            MD_AREF: c = CK_AREF;
            default: c = CK_NOP;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/dix_mode_reg.sv
module dix_mode_reg
    import dix_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [2:0] wr_data,
    output mode_e      mode_q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MD_IDLE;
        end else if (wr_en && (wr_data != 3'(MD_RSVD))) begin
            mode_q <= mode_e'(wr_data);
        end
    end

endmodule

// File: rtl/dix_cmd_enc.sv
module dix_cmd_enc
    import dix_pkg::*;
#(
    parameter int MA_W   = 13,
    parameter int BA_W   = 2,
    parameter int AP_BIT = 10
) (
    input  cmd_e              cmd,
    input  logic [MA_W-1:0]   addr,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [BA_W-1:0]   ba,
    output logic [MA_W-1:0]   ma
);

    always_comb begin
        cs_n  = 1'b0;
        ras_n = 1'b1;
        cas_n = 1'b1;
        we_n  = 1'b1;
        ba    = '0;
        ma    = '0;
        unique case (cmd)
            CK_NOP: begin
            end
            CK_PREA: begin
                ras_n      = 1'b0;
                we_n       = 1'b0;
                ma[AP_BIT] = 1'b1;
            end
            CK_MRS: begin
                ras_n = 1'b0;
                cas_n = 1'b0;
                we_n  = 1'b0;
                ma    = addr;
            end
            CK_EMRS: begin
                ras_n = 1'b0;
                cas_n = 1'b0;
                we_n  = 1'b0;
                ba    = BA_W'(1);
                ma    = addr;
            end
            CK_AREF: begin
                ras_n = 1'b0;
                cas_n = 1'b0;
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/dix_pwr_fsm.sv
module dix_pwr_fsm
    import dix_pkg::*;
#(
    parameter int HADDR_W   = 16,
    parameter int MA_W      = 13,
    parameter int MA_LSB    = 3,
    parameter int CNT_W     = 4,
    parameter int EXIT_NOPS = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  mode_e              mode,
    input  logic               host_req,
    input  logic [HADDR_W-1:0] host_addr,
    input  logic               susp_req,
    input  logic               lp_req,
    input  logic [CNT_W-1:0]   pend_cnt,
    output logic               cke_q,
    output cmd_e               cmd_q,
    output logic [MA_W-1:0]    maddr_q,
    output logic               ack_q,
    output logic               pv_q,
    output logic [HADDR_W-1:0] paddr_q
);

    localparam int XW = (EXIT_NOPS < 2) ? 1 : $clog2(EXIT_NOPS);
    localparam logic [XW-1:0] X_LAST = XW'(EXIT_NOPS - 1);

    state_e             st_q, st_d;
    logic               susp_q, susp_d;
    logic [XW-1:0]      xcnt_q, xcnt_d;
    logic               cke_d, ack_d, pv_d;
    cmd_e               cmd_d;
    logic [MA_W-1:0]    maddr_d;
    logic [HADDR_W-1:0] paddr_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_CKE_OFF;
        end else begin
            st_q <= st_d;
        end
    end

    // next state and next outputs
    always_comb begin
        st_d    = st_q;
        susp_d  = susp_q;
        xcnt_d  = xcnt_q;
        cke_d   = cke_q;
        cmd_d   = CK_NOP;
        maddr_d = '0;
        ack_d   = 1'b0;
        pv_d    = 1'b0;
        paddr_d = paddr_q;
        unique case (st_q)
            ST_CKE_OFF: begin
                cke_d = 1'b0;
                if (mode != MD_IDLE) begin
                    st_d  = ST_RUN;
                    cke_d = 1'b1;
                end
            end
            ST_RUN: begin
                cke_d = 1'b1;
                if (susp_req || lp_req) begin
                    st_d   = ST_FLUSH;
                    susp_d = susp_req;
                end else if (host_req && !ack_q) begin
                    ack_d = 1'b1;
                    if (mode == MD_NORM) begin
                        pv_d    = 1'b1;
                        paddr_d = host_addr;
                    end else begin
                        cmd_d   = mode_to_cmd(mode);
                        maddr_d = host_addr[MA_LSB +: MA_W];
                    end
                end
            end
            ST_FLUSH: begin
                if (susp_req) begin
                    susp_d = 1'b1;
                end
                if (pend_cnt == '0) begin
                    st_d  = ST_SR_ENTRY;
                    cke_d = 1'b0;
                    cmd_d = CK_AREF;
                end
            end
            ST_SR_ENTRY: begin
                cke_d = 1'b0;
                st_d  = susp_q ? ST_SUSP_HOLD : ST_SR_HOLD;
            end
            ST_SR_HOLD: begin
                cke_d = 1'b0;
                if (susp_req) begin
                    st_d = ST_SUSP_HOLD;
                end else if (!lp_req) begin
                    st_d   = ST_SR_EXIT;
                    cke_d  = 1'b1;
                    xcnt_d = '0;
                end
            end
            ST_SR_EXIT: begin
                cke_d = 1'b1;
                if (xcnt_q == X_LAST) begin
                    st_d = ST_RUN;
                end else begin
                    xcnt_d = xcnt_q + 1'b1;
                end
            end
            ST_SUSP_HOLD: begin
                cke_d = 1'b0;
            end
            default: begin
                st_d = ST_CKE_OFF;
            end
        endcase
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            susp_q  <= 1'b0;
            xcnt_q  <= '0;
            cke_q   <= 1'b0;
            cmd_q   <= CK_NOP;
            maddr_q <= '0;
            ack_q   <= 1'b0;
            pv_q    <= 1'b0;
            paddr_q <= '0;
        end else begin
            susp_q  <= susp_d;
            xcnt_q  <= xcnt_d;
            cke_q   <= cke_d;
            cmd_q   <= cmd_d;
            maddr_q <= maddr_d;
            ack_q   <= ack_d;
            pv_q    <= pv_d;
            paddr_q <= paddr_d;
        end
    end

endmodule

// File: rtl/dram_init_xlate.sv
module dram_init_xlate
    import dix_pkg::*;
#(
    parameter int NCKE      = 2,
    parameter int HADDR_W   = 16,
    parameter int MA_W      = 13,
    parameter int MA_LSB    = 3,
    parameter int BA_W      = 2,
    parameter int CNT_W     = 4,
    parameter int EXIT_NOPS = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               mode_wr_en,
    input  logic [2:0]         mode_wr_data,
    output logic [2:0]         mode_q,
    input  logic               host_req,
    input  logic [HADDR_W-1:0] host_addr,
    output logic               host_ack,
    output logic               pass_valid,
    output logic [HADDR_W-1:0] pass_addr,
    input  logic               susp_req,
    input  logic               lp_req,
    input  logic [CNT_W-1:0]   pend_cnt,
    output logic [NCKE-1:0]    dram_cke,
    output logic               dram_cs_n,
    output logic               dram_ras_n,
    output logic               dram_cas_n,
    output logic               dram_we_n,
    output logic [BA_W-1:0]    dram_ba,
    output logic [MA_W-1:0]    dram_ma
);

    mode_e           mode;
    cmd_e            cmd;
    logic [MA_W-1:0] maddr;
    logic            cke_one;

    dix_mode_reg u_mode (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (mode_wr_en),
        .wr_data (mode_wr_data),
        .mode_q  (mode)
    );

    assign mode_q = 3'(mode);

    dix_pwr_fsm #(
        .HADDR_W   (HADDR_W),
        .MA_W      (MA_W),
        .MA_LSB    (MA_LSB),
        .CNT_W     (CNT_W),
        .EXIT_NOPS (EXIT_NOPS)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode),
        .host_req  (host_req),
        .host_addr (host_addr),
        .susp_req  (susp_req),
        .lp_req    (lp_req),
        .pend_cnt  (pend_cnt),
        .cke_q     (cke_one),
        .cmd_q     (cmd),
        .maddr_q   (maddr),
        .ack_q     (host_ack),
        .pv_q      (pass_valid),
        .paddr_q   (pass_addr)
    );

    dix_cmd_enc #(
        .MA_W (MA_W),
        .BA_W (BA_W)
    ) u_enc (
        .cmd   (cmd),
        .addr  (maddr),
        .cs_n  (dram_cs_n),
        .ras_n (dram_ras_n),
        .cas_n (dram_cas_n),
        .we_n  (dram_we_n),
        .ba    (dram_ba),
        .ma    (dram_ma)
    );

    for (genvar g = 0; g < NCKE; g++) begin : g_cke
        assign dram_cke[g] = cke_one;
    end

endmodule

// File: rtl/dix_chk.sv
module dix_chk #(
    parameter int NCKE  = 2,
    parameter int CNT_W = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            mode_wr_en,
    input logic [2:0]      mode_wr_data,
    input logic [2:0]      mode_q,
    input logic            host_ack,
    input logic            pass_valid,
    input logic [CNT_W-1:0] pend_cnt,
    input logic [NCKE-1:0] dram_cke,
    input logic            dram_cs_n,
    input logic            dram_ras_n,
    input logic            dram_cas_n,
    input logic            dram_we_n
);

    logic [3:0] bus;
    logic       seen_q;

    assign bus = {dram_cs_n, dram_ras_n, dram_cas_n, dram_we_n};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q <= 1'b0;
        end else if (mode_q != 3'd0) begin
            seen_q <= 1'b1;
        end
    end

    assert_cke_uniform_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(dram_cke) == 0) || ($countones(dram_cke) == NCKE));

    assert_cke_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_q |-> (dram_cke == '0));

    assert_rsvd_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_wr_en && mode_wr_data == 3'd5) |=> $stable(mode_q));

    assert_rsvd_never_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q != 3'd5);

    assert_ack_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        host_ack |=> !host_ack);

    assert_cmd_acked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (dram_cke[0] && bus != 4'b0111) |-> host_ack);

    assert_pass_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pass_valid |-> (host_ack && bus == 4'b0111));

    assert_sr_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dram_cke[0]) |-> (bus == 4'b0001 && $past(pend_cnt) == '0));

    assert_exit_nop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dram_cke[0]) |-> (bus == 4'b0111));

endmodule

bind dram_init_xlate dix_chk #(
    .NCKE  (NCKE),
    .CNT_W (CNT_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_wr_en   (mode_wr_en),
    .mode_wr_data (mode_wr_data),
    .mode_q       (mode_q),
    .host_ack     (host_ack),
    .pass_valid   (pass_valid),
    .pend_cnt     (pend_cnt),
    .dram_cke     (dram_cke),
    .dram_cs_n    (dram_cs_n),
    .dram_ras_n   (dram_ras_n),
    .dram_cas_n   (dram_cas_n),
    .dram_we_n    (dram_we_n)
);

// File: tb/dram_init_xlate_tb_top.sv
module dram_init_xlate_tb_top;

    localparam int NCKE = 2;
    localparam int HW   = 16;
    localparam int MW   = 13;
    localparam int BW   = 2;
    localparam int CW   = 4;
    localparam int XN   = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mode_wr_en = 1'b0;
    logic [2:0]    mode_wr_data = '0;
    logic [2:0]    mode_q;
    logic          host_req = 1'b0;
    logic [HW-1:0] host_addr = '0;
    logic          host_ack;
    logic          pass_valid;
    logic [HW-1:0] pass_addr;
    logic          susp_req = 1'b0;
    logic          lp_req = 1'b0;
    logic [CW-1:0] pend_cnt = '0;
    logic [NCKE-1:0] dram_cke;
    logic          dram_cs_n, dram_ras_n, dram_cas_n, dram_we_n;
    logic [BW-1:0] dram_ba;
    logic [MW-1:0] dram_ma;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    dram_init_xlate #(
        .NCKE (NCKE), .HADDR_W (HW), .MA_W (MW), .MA_LSB (3),
        .BA_W (BW), .CNT_W (CW), .EXIT_NOPS (XN)
    ) dut_i (
        .clk (clk), .rst_n (rst_n),
        .mode_wr_en (mode_wr_en), .mode_wr_data (mode_wr_data), .mode_q (mode_q),
        .host_req (host_req), .host_addr (host_addr), .host_ack (host_ack),
        .pass_valid (pass_valid), .pass_addr (pass_addr),
        .susp_req (susp_req), .lp_req (lp_req), .pend_cnt (pend_cnt),
        .dram_cke (dram_cke), .dram_cs_n (dram_cs_n), .dram_ras_n (dram_ras_n),
        .dram_cas_n (dram_cas_n), .dram_we_n (dram_we_n),
        .dram_ba (dram_ba), .dram_ma (dram_ma)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] bus();
        return {dram_cs_n, dram_ras_n, dram_cas_n, dram_we_n};
    endfunction

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    task automatic wr_mode(input logic [2:0] v);
        @(negedge clk);
        mode_wr_en   = 1'b1;
        mode_wr_data = v;
        @(negedge clk);
        mode_wr_en   = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // expected bus word {cs,ras,cas,we,ba,ma,pass_valid}
    function automatic logic [31:0] exp_word(input logic [2:0] m, input logic [15:0] a);
        logic [3:0]  c;
        logic [1:0]  b;
        logic [12:0] x;
        logic        p;
        c = 4'b0111; b = 2'd0; x = '0; p = 1'b0;
        case (m)
            3'd2: begin c = 4'b0010; x = 13'd1 << 10; end
            3'd3: begin c = 4'b0000; x = a[15:3]; end
            3'd4: begin c = 4'b0000; b = 2'd1; x = a[15:3]; end
            3'd6: c = 4'b0001;
            3'd7: p = 1'b1;
            default: ;
        endcase
        return {12'd0, c, b, x, p};
    endfunction

    task automatic access(input logic [15:0] a, input logic [2:0] em, input string tag);
        logic [31:0] got;
        @(negedge clk);
        host_req  = 1'b1;
        host_addr = a;
        @(negedge clk);
        check(host_ack === 1'b1, {tag, " ack in command cycle (R6)"}, 32'(host_ack), 32'd1);
        got = {12'd0, bus(), dram_ba, dram_ma, pass_valid};
        check(got === exp_word(em, a), {tag, " command pins"}, got, exp_word(em, a));
        if (em == 3'd7)
            check(pass_addr === a, "R7 pass_addr", 32'(pass_addr), 32'(a));
        host_req = 1'b0;
        @(negedge clk);
        check(host_ack === 1'b0 && bus() == 4'b0111 && pass_valid === 1'b0,
              "R6 single ack then NOP", {27'd0, host_ack, bus()}, 32'h7);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=%0d expected=0", 1);
        finish_run();
    end

    initial begin
        logic [2:0] exp_m;
        int n;
        // R1 during reset and after release
        repeat (2) @(negedge clk);
        check(dram_cke === '0 && mode_q === 3'd0, "R1 reset state", {dram_cke, mode_q}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(mode_q === 3'd0, "R1 mode cleared", 32'(mode_q), 32'd0);
        check(dram_cke === '0, "R1 cke low", 32'(dram_cke), 32'd0);
        check(bus() === 4'b0111, "R1 bus NOP", 32'(bus()), 32'h7);
        check(host_ack === 1'b0 && pass_valid === 1'b0, "R1 no ack", 32'(host_ack), 32'd0);

        // R2 / R11: held access while mode 000; writes of 000 and 101
        host_req = 1'b1;
        wr_mode(3'd0);
        wr_mode(3'd5);
        check(mode_q === 3'd0, "R3 101 ignored at 000", 32'(mode_q), 32'd0);
        repeat (3) @(negedge clk);
        check(dram_cke === '0, "R2 cke low while mode 000", 32'(dram_cke), 32'd0);
        check(host_ack === 1'b0, "R2 no ack while cke low", 32'(host_ack), 32'd0);
        host_req = 1'b0;

        // R2 release timing
        @(negedge clk);
        mode_wr_en = 1'b1; mode_wr_data = 3'd1;
        @(negedge clk);
        mode_wr_en = 1'b0;
        check(mode_q === 3'd1, "R2 mode stored", 32'(mode_q), 32'd1);
        check(dram_cke === '0, "R2 cke one cycle later", 32'(dram_cke), 32'd0);
        @(negedge clk);
        check(dram_cke === {NCKE{1'b1}}, "R2 all cke high", 32'(dram_cke), 32'h3);
        exp_m = 3'd1;

        // sweep every mode code with three address patterns
        for (int m = 0; m < 8; m++) begin
            wr_mode(3'(m));
            if (m != 5) exp_m = 3'(m);
            check(mode_q === exp_m, "R3 stored mode", 32'(mode_q), 32'(exp_m));
            for (int k = 0; k < 3; k++) begin
                logic [15:0] a;
                a = (k == 0) ? 16'hFFF8 : (k == 1) ? 16'h0007 : 16'(16'hA5A8 ^ (m * 16'h1248));
                if (exp_m == 3'd3 || exp_m == 3'd4) access(a, exp_m, "R5");
                else if (exp_m == 3'd7) access(a, exp_m, "R7");
                else access(a, exp_m, "R4");
            end
        end

        // R8 low-power entry with drain
        wr_mode(3'd2);
        @(negedge clk);
        lp_req = 1'b1; pend_cnt = 4'd3;
        @(negedge clk);
        host_req = 1'b1; host_addr = 16'h0010;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(dram_cke === {NCKE{1'b1}} && bus() === 4'b0111, "R8 drain keeps cke NOP",
                  {dram_cke, bus()}, 32'h37);
            check(host_ack === 1'b0, "R11 no ack in flush", 32'(host_ack), 32'd0);
            pend_cnt = pend_cnt - 1'b1;
        end
        @(negedge clk);
        check(dram_cke === '0 && bus() === 4'b0001, "R8 refresh with cke falling",
              {dram_cke, bus()}, 32'h01);
        repeat (4) begin
            @(negedge clk);
            check(dram_cke === '0 && host_ack === 1'b0, "R11 self-refresh hold",
                  {dram_cke, host_ack}, 32'd0);
        end

        // R9 exit without software
        lp_req = 1'b0;
        n = 0;
        @(negedge clk);
        check(dram_cke === {NCKE{1'b1}} && bus() === 4'b0111, "R9 cke rises with NOP",
              {dram_cke, bus()}, 32'h37);
        while (!host_ack && n < 10) begin
            check(bus() === 4'b0111 && dram_cke === {NCKE{1'b1}}, "R9 exit NOP",
                  32'(bus()), 32'h7);
            n++;
            @(negedge clk);
        end
        check(n == XN + 1, "R9 exit NOP count", 32'(n), 32'(XN + 1));
        check(bus() === 4'b0010 && mode_q === 3'd2, "R9 resumes in same mode",
              {mode_q, bus()}, {3'd2, 4'b0010});
        host_req = 1'b0;
        @(negedge clk);

        // R10 suspend
        susp_req = 1'b1;
        n = 0;
        @(negedge clk);
        while (dram_cke !== '0 && n < 6) begin
            n++;
            @(negedge clk);
        end
        check(bus() === 4'b0001 && dram_cke === '0, "R10 suspend enters via refresh",
              {dram_cke, bus()}, 32'h01);
        susp_req = 1'b0; lp_req = 1'b0; host_req = 1'b1;
        repeat (8) @(negedge clk);
        check(dram_cke === '0 && host_ack === 1'b0, "R10 stays until reset",
              {dram_cke, host_ack}, 32'd0);
        host_req = 1'b0;
        do_reset();
        @(negedge clk);
        check(mode_q === 3'd0 && dram_cke === '0, "R10 reset restores off state",
              {mode_q, dram_cke}, 32'd0);
        @(negedge clk);
        mode_wr_en = 1'b1; mode_wr_data = 3'd6;
        @(negedge clk);
        mode_wr_en = 1'b0;
        check(dram_cke === '0, "R10 cke waits after write", 32'(dram_cke), 32'd0);
        @(negedge clk);
        check(dram_cke === {NCKE{1'b1}}, "R10 cke up after nonzero mode", 32'(dram_cke), 32'h3);
        access(16'h1238, 3'd6, "R4");

        finish_run();
    end

endmodule